// File: doc/BRIEF.md
# Per-Processor Countdown Interrupt Timer

This block is the timer that sits beside each processor's interrupt controller. A bus clock feeds a power-of-two prescaler. Each prescaled tick lowers a 32-bit down-counter by one. Software controls the block through four word registers:
- a timer entry holding the interrupt vector, a mask bit and a mode bit;
- an initial-count register;
- a read-only current-count register;
- a divide-select register.

Writing the initial count loads the counter and restarts the prescaler phase, so software programs the next event relative to the present moment. The elapsed ticks between two reads of the current count equal the earlier value minus the later one.

When the counter arrives at zero, the block raises a one-cycle interrupt request carrying the programmed vector, unless the entry is masked. What follows depends on the mode bit:
- In repeating mode the counter takes the initial count again on the next prescaled tick.
- In single-shot mode the counter rests at zero.

Shutting the timer down means setting the mask while keeping a legal vector. A vector of zero is illegal: writing one is flagged, and it never produces a request.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset, the timer entry reads 0x0001_0000 (masked, vector 0, single-shot), and the initial count, current count and divide register all read 0. The interrupt request and the error flag are low.
- R2: A write of a non-zero value N to the initial-count register (word address 1) makes the current count (word address 2) read N in the next cycle. From then on it drops by one on each prescaled tick.
- R3: The divide register (word address 3) uses bits {3,1,0} as a 3-bit code. 000=/2, 001=/4, 010=/8, 011=/16, 100=/32, 101=/64, 110=/128 and 111=/1. Bit 2 reads 0. After a write of N, the count reaches zero N*D bus cycles later, where D is the divisor.
- R4: In the cycle where the count first reads zero, irq_req is high for exactly one cycle. In that cycle irq_vector holds the entry vector (entry bits 7:0). This holds when the entry is unmasked and the vector is non-zero.
- R5: With the mask (entry bit 16) set, no request is raised, but the counter keeps counting, reloading and reading back as in unmasked operation.
- R6: In single-shot mode (entry bit 17 clear), the count stays at zero after reaching it, and no further request follows.
- R7: In repeating mode (entry bit 17 set), the count reloads to the initial value on the prescaled tick after zero. Requests therefore repeat every (N+1)*D bus cycles.
- R8: Writing an initial count of zero stops the counter at zero, and no request follows.
- R9: The current-count register is read-only. A write to word address 2 leaves the count and all other registers unchanged.
- R10: A timer-entry write (word address 0) whose vector field is zero pulses cfg_err in the following cycle. A zero vector never produces a request.
- R11: Rewriting the initial count while counting restarts the countdown from the new value, with the prescaler phase reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the combinational read |
| rd_data | output | 32 | Read data |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector accompanying the request |
| cfg_err | output | 1 | One-cycle pulse after an illegal zero vector is written |

## Verification
The bench measures the exact distance, in bus cycles, from an initial-count write to the request, for every divide code and for random counts and vectors. An off-by-one in the prescaler phase or the terminal count shows up there as a latency one tick too long or too short. It measures the gap between repeating requests, which exposes a design that reloads on the zero cycle itself or skips the reload tick. It also checks that masked or zero-vector runs stay silent while the count keeps moving, that single-shot runs never fire twice, and that rewrites, zero writes and writes to the read-only register change the count exactly as specified.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int VEC_W   = 8;
    localparam int PRESC_W = 7;   // largest divisor is 2**PRESC_W

    localparam int ADDR_ENTRY = 0;
    localparam int ADDR_INIT  = 1;
    localparam int ADDR_CUR   = 2;
    localparam int ADDR_DIV   = 3;

    localparam int ENTRY_MASK_BIT = 16;
    localparam int ENTRY_PER_BIT  = 17;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } entry_t;

    typedef logic [2:0] div_code_t;

    // Pull the scattered code bits {3,1,0} out of a divide write.
    function automatic div_code_t div_code_from_word(input logic [31:0] w);
        return {w[3], w[1], w[0]};
    endfunction

    // Phase mask of the prescaler: tick when all masked bits are one.
    function automatic logic [PRESC_W-1:0] div_phase_mask(input div_code_t c);
        logic [PRESC_W-1:0] m;
        if (c == 3'b111) begin
            m = '0;
        end else begin
            m = PRESC_W'((1 << (int'(c) + 1)) - 1);
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PW = PRESC_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  div_code_t div_code,
    output logic      tick
);
    logic [PW-1:0] phase_q;
    logic [PW-1:0] pmask;

    always_comb begin
        pmask = PW'(div_phase_mask(div_code));
        tick  = ((phase_q & pmask) == pmask);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cur_count,
    output entry_t            entry,
    output logic [CNT_W-1:0]  init_count,
    output div_code_t         div_code,
    output logic              init_wr,
    output logic [31:0]       rd_data,
    output logic              cfg_err
);
    localparam logic [ADDR_W-1:0] A_ENTRY = ADDR_W'(ADDR_ENTRY);
    localparam logic [ADDR_W-1:0] A_INIT  = ADDR_W'(ADDR_INIT);
    localparam logic [ADDR_W-1:0] A_CUR   = ADDR_W'(ADDR_CUR);
    localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(ADDR_DIV);

    entry_t           entry_q;
    logic [CNT_W-1:0] init_q;
    div_code_t        div_q;
    logic             err_q;
    logic             entry_wr;
    logic             div_wr;

    always_comb begin
        entry_wr = wr_en && (wr_addr == A_ENTRY);
        init_wr  = wr_en && (wr_addr == A_INIT);
        div_wr   = wr_en && (wr_addr == A_DIV);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= '{periodic: 1'b0, mask: 1'b1, vector: '0};
            init_q  <= '0;
            div_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= entry_wr && (wr_data[VEC_W-1:0] == '0);
            if (entry_wr) begin
                entry_q.vector   <= wr_data[VEC_W-1:0];
                entry_q.mask     <= wr_data[ENTRY_MASK_BIT];
                entry_q.periodic <= wr_data[ENTRY_PER_BIT];
            end
            if (init_wr) begin
                init_q <= CNT_W'(wr_data);
            end
            if (div_wr) begin
                div_q <= div_code_from_word(wr_data);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_ENTRY: begin
                rd_data[VEC_W-1:0]     = entry_q.vector;
                rd_data[ENTRY_MASK_BIT] = entry_q.mask;
                rd_data[ENTRY_PER_BIT]  = entry_q.periodic;
            end
            A_INIT:  rd_data = 32'(init_q);
            A_CUR:   rd_data = 32'(cur_count);
            A_DIV:   rd_data = {28'd0, div_q[2], 1'b0, div_q[1], div_q[0]};
            default: rd_data = '0;
        endcase
    end

    assign entry      = entry_q;
    assign init_count = init_q;
    assign div_code   = div_q;
    assign cfg_err    = err_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  entry_t           entry,
    output logic [CNT_W-1:0] count,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector
);
    typedef enum logic [1:0] { ST_IDLE, ST_RUN } run_e;

    logic [CNT_W-1:0] cnt_q;
    run_e             st_q;
    logic             irq_q;
    logic [VEC_W-1:0] vec_q;
    logic             fire_ok;

    assign fire_ok = !entry.mask && (entry.vector != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= 1'b0;
            if (load) begin
                cnt_q <= load_val;
                st_q  <= (load_val != '0) ? ST_RUN : ST_IDLE;
            end else if (st_q == ST_RUN && tick) begin
                if (cnt_q == '0) begin
                    // only reachable in repeating mode: reload or stop
                    if (entry.periodic) begin
                        cnt_q <= reload_val;
                    end else begin
                        st_q <= ST_IDLE;
                    end
                end else if (cnt_q == CNT_W'(1)) begin
                    cnt_q <= '0;
                    irq_q <= fire_ok;
                    if (fire_ok) begin
                        vec_q <= entry.vector;
                    end
                    if (!entry.periodic) begin
                        st_q <= ST_IDLE;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign count      = cnt_q;
    assign irq_req    = irq_q;
    assign irq_vector = vec_q;
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector,
    output logic              cfg_err
);
    entry_t           entry_q;
    logic [CNT_W-1:0] init_count;
    logic [CNT_W-1:0] cur_count;
    div_code_t        div_code;
    logic             init_wr;
    logic             tick;

    tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .cur_count  (cur_count),
        .entry      (entry_q),
        .init_count (init_count),
        .div_code   (div_code),
        .init_wr    (init_wr),
        .rd_data    (rd_data),
        .cfg_err    (cfg_err)
    );

    tmr_prescaler #(.PW(PRESC_W)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .restart  (init_wr),
        .div_code (div_code),
        .tick     (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (init_wr),
        .load_val   (CNT_W'(wr_data)),
        .reload_val (init_count),
        .tick       (tick),
        .entry      (entry_q),
        .count      (cur_count),
        .irq_req    (irq_req),
        .irq_vector (irq_vector)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             init_wr,
    input logic [31:0]      wr_data,
    input logic [CNT_W-1:0] cur,
    input entry_t           entry,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vector
);
    // R2: a load is visible in the next cycle
    p_load_visible_r2: assert property (@(posedge clk) disable iff (rst)
        init_wr |=> (cur == CNT_W'($past(wr_data))));

    // R2: without a load the count only holds or steps down by one
    p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
        (!init_wr && cur != '0) |=> (cur == $past(cur) || cur == $past(cur) - 1'b1));

    // R4: a request lasts one cycle and coincides with a zero count
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        irq_req |=> !irq_req);
    p_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (cur == '0));

    // R5: no request follows a masked entry
    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> !$past(entry.mask));

    // R6: single-shot count rests at zero
    p_oneshot_rest_r6: assert property (@(posedge clk) disable iff (rst)
        (cur == '0 && !entry.periodic && !init_wr) |=> (cur == '0));

    // R10: a zero vector never accompanies a request
    p_no_zero_vec_r10: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vector != '0));
endmodule

bind irq_countdown_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .init_wr    (init_wr),
    .wr_data    (wr_data),
    .cur        (cur_count),
    .entry      (entry_q),
    .irq_req    (irq_req),
    .irq_vector (irq_vector)
);

// File: tb/irq_countdown_timer_tb_top.sv
`timescale 1ns/1ps
module irq_countdown_timer_tb_top;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic              irq_req;
    logic [7:0]        irq_vector;
    logic              cfg_err;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    irq_countdown_timer #(.ADDR_W(ADDR_W), .CNT_W(32)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_req(irq_req), .irq_vector(irq_vector), .cfg_err(cfg_err)
    );

    function automatic int divisor(input int code);
        return (code == 7) ? 1 : (1 << (code + 1));
    endfunction

    function automatic logic [31:0] div_word(input int code);
        return {28'd0, code[2], 1'b0, code[1], code[0]};
    endfunction

    function automatic logic [31:0] entry_word(input logic per, input logic msk,
                                               input logic [7:0] vec);
        return {14'd0, per, msk, 8'd0, vec};
    endfunction

    task automatic check(input bit ok, input string req, input longint act,
                         input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        rd_addr = ADDR_W'(addr);
        #0.5;
        data = rd_data;
    endtask

    task automatic run_cycles(input int n, output int irqs);
        irqs = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (irq_req) irqs++;
        end
    endtask

    task automatic wait_irq(input int limit, output int edges, output logic [7:0] vec);
        edges = 0;
        vec = '0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            #1;
            edges++;
            if (irq_req) begin
                vec = irq_vector;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int e, n;
        logic [7:0] v;
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(0, d); check(d == 32'h0001_0000, "R1 entry", d, 32'h0001_0000);
        rd(1, d); check(d == 0, "R1 init", d, 0);
        rd(2, d); check(d == 0, "R1 cur", d, 0);
        rd(3, d); check(d == 0, "R1 div", d, 0);
        check(!irq_req && !cfg_err, "R1 outputs", {irq_req, cfg_err}, 0);

        // R2 load and step, divide /1
        wr(3, div_word(7));
        wr(0, entry_word(1'b0, 1'b0, 8'h31));
        wr(1, 32'd10);
        rd(2, d); check(d == 10, "R2 load visible", d, 10);
        run_cycles(3, e);
        rd(2, d); check(d == 7, "R2 step down", d, 7);
        wait_irq(50, e, v);
        check(e == 7, "R4 latency rest", e, 7);
        check(v == 8'h31, "R4 vector", v, 8'h31);
        run_cycles(1, n);
        check(!irq_req, "R4 single cycle", irq_req, 0);
        // R6 single-shot rests
        run_cycles(40, n);
        check(n == 0, "R6 no repeat", n, 0);
        rd(2, d); check(d == 0, "R6 rests at zero", d, 0);

        // R3 each divide code, N=2
        for (int c = 0; c < 8; c++) begin
            wr(3, div_word(c));
            rd(3, d); check(d == div_word(c), "R3 readback", d, div_word(c));
            wr(1, 32'd2);
            wait_irq(2 * divisor(c) + 50, e, v);
            check(e == 2 * divisor(c), "R3 latency", e, 2 * divisor(c));
        end

        // R7 repeating mode, /4, N=5
        wr(3, div_word(1));
        wr(0, entry_word(1'b1, 1'b0, 8'hA5));
        wr(1, 32'd5);
        wait_irq(100, e, v);
        check(e == 20, "R7 first", e, 20);
        for (int k = 0; k < 3; k++) begin
            wait_irq(100, e, v);
            check(e == 24, "R7 period", e, 24);
            check(v == 8'hA5, "R7 vector", v, 8'hA5);
        end

        // R8 zero write stops
        wr(1, 32'd0);
        rd(2, d); check(d == 0, "R8 stopped", d, 0);
        run_cycles(60, n);
        check(n == 0, "R8 no irq", n, 0);

        // R5 masked repeating, /1, N=5: counter runs and reloads silently
        wr(3, div_word(7));
        wr(0, entry_word(1'b1, 1'b1, 8'h40));
        wr(1, 32'd5);
        run_cycles(3, n);
        rd(2, d); check(d == 2, "R5 runs masked", d, 2);
        run_cycles(3, e);
        rd(2, d); check(d == 5, "R5 reloads masked", d, 5);
        run_cycles(30, e);
        check(n + e == 0, "R5 silent", n + e, 0);

        // R9 write to current count ignored
        wr(0, entry_word(1'b0, 1'b0, 8'h22));
        wr(1, 32'd20);
        wr(2, 32'd3);
        rd(2, d); check(d == 19, "R9 count unchanged", d, 19);
        rd(1, d); check(d == 20, "R9 init unchanged", d, 20);
        rd(0, d); check(d == entry_word(1'b0, 1'b0, 8'h22), "R9 entry unchanged", d, 0);
        wr(1, 32'd0);

        // R10 zero vector flagged and silent
        wr(0, entry_word(1'b0, 1'b0, 8'h00));
        check(cfg_err == 1'b1, "R10 err pulse", cfg_err, 1);
        run_cycles(1, n);
        check(cfg_err == 1'b0, "R10 err one cycle", cfg_err, 0);
        wr(1, 32'd3);
        run_cycles(20, n);
        check(n == 0, "R10 no irq zero vector", n, 0);
        wr(0, entry_word(1'b0, 1'b0, 8'h10));
        check(cfg_err == 1'b0, "R10 legal no err", cfg_err, 0);

        // R11 restart mid-count, /8
        wr(3, div_word(2));
        wr(1, 32'd10);
        run_cycles(13, n);
        wr(1, 32'd6);
        wait_irq(200, e, v);
        check(e == 48, "R11 restart latency", e, 48);

        // random mix (R3, R4)
        for (int it = 0; it < 24; it++) begin
            int c, cnt;
            logic [7:0] vec;
            c = int'($urandom_range(7, 0));
            cnt = int'($urandom_range(20, 1));
            vec = 8'($urandom_range(255, 1));
            wr(3, div_word(c));
            wr(0, entry_word(1'b0, 1'b0, vec));
            wr(1, 32'(cnt));
            wait_irq(cnt * divisor(c) + 100, e, v);
            check(e == cnt * divisor(c), "R3 random latency", e, cnt * divisor(c));
            check(v == vec, "R4 random vector", v, vec);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule